// File: doc/BRIEF.md
# Flash Bus Read Front End

This block is the memory-side front end of a 32-bit parallel flash device. It watches the asynchronous bus strobes (chip select, read strobe, write strobe, output inhibit and address latch strobe), samples them on a fast internal clock and turns them into read and write cycles. Reads are served either from a behavioural word array or from a small set of internal registers: a device identifier, a protection word, a status word, a query word and a burst configuration register.

The address passes through a latch that follows the address pins while the latch strobe is low and freezes when it goes high. A read access starts at whichever comes last: an address change seen through the latch, chip select falling, or the latch strobe falling. Read data appears a fixed, parameterized number of internal clocks after that start. The block powers up in asynchronous mode. Synchronous mode can only be entered by writing the burst configuration register, and reads of register space are always reported as asynchronous.

Top module: `flash_rd_frontend`

## Requirements
- R1: While and directly after reset, `rd_drive`, `rd_valid`, `rd_sync` and `sync_mode` are 0 and `rd_data` is all zeros.
- R2: `rd_drive` is 1 exactly when the sampled strobes show chip select low, read strobe low, write strobe high and output inhibit high. Any input change sampled at clock edge k shows on `rd_drive` after edge k+2.
- R3: `rd_valid` rises ACC_LAT+3 edges after the edge that first samples the start event, provided the read condition of R2 holds. Whenever `rd_valid` is 0, `rd_data` is all zeros.
- R4: A start event (chip select falling, latch strobe falling, or a new address while the latch is transparent) drops `rd_valid` and restarts the ACC_LAT count.
- R5: While the latch strobe is high, changes on `addr` do not change the word read and do not restart the access. The address in use is the one present when the strobe rose.
- R6: With the latch strobe held low, the latch is transparent and a plain read returns the word at the current address.
- R7: Address bit AW-1 = 1 selects register space, decoded by the low 3 bits: 0 identifier (SIG_WORD), 1 protection (PROT_WORD), 2 status (STAT_WORD), 3 query (QUERY_WORD), 4 burst configuration, others read 0.
- R8: A write takes effect when the sampled write strobe rises while chip select is low. A write to register index 4 loads the burst configuration register. Its bit 0 is 1 after reset (asynchronous), and `sync_mode` is 1 only while that bit holds 0.
- R9: `rd_sync` is 1 during a read only when `sync_mode` is 1 and the latched address is in array space. Register-space reads always give `rd_sync` = 0.
- R10: A write with address bit AW-1 = 0 stores `wdata` in the array word given by the low AW-1 address bits, and a later read of that address returns it.
- R11: Reset returns the block to asynchronous mode (`sync_mode` = 0) after synchronous mode was entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| od_n | input | 1 | Output inhibit, active low |
| le_n | input | 1 | Address latch strobe, transparent when low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rd_data | output | DW | Read data, zero when not valid |
| rd_drive | output | 1 | Data bus drive enable (tri-state control) |
| rd_valid | output | 1 | Read data valid |
| rd_sync | output | 1 | Current read served in synchronous mode |
| sync_mode | output | 1 | Burst configuration selects synchronous mode |

## Verification
The assertions take the pin inputs to be held long enough to pass the two-flop sampling cleanly, and reset to be held for at least two clocks so the sampled strobes start idle. They also take writes to the array to be finished a few clocks before a read of the same word begins, because the array is read through a registered port. The stimulus changes inputs only on the falling clock edge, holds each strobe level for three or more clocks, and keeps the read strobe high around every write cycle, so all of this holds.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  // Register-space index decoded from the low address bits
  localparam logic [2:0] RIDX_SIG   = 3'd0;
  localparam logic [2:0] RIDX_PROT  = 3'd1;
  localparam logic [2:0] RIDX_STAT  = 3'd2;
  localparam logic [2:0] RIDX_QUERY = 3'd3;
  localparam logic [2:0] RIDX_BCFG  = 3'd4;

  // Sampled bus strobes, all active low
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic od_n;
    logic le_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = 5'b11111;

endpackage

// File: rtl/frd_sync.sv
// Two-flop sampler for asynchronous pins
module frd_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/frd_addr_latch.sv
// Transparent-low address latch, access start detection, latency counter
module frd_addr_latch #(
  parameter int AW      = 10,
  parameter int ACC_LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          le_s,
  input  logic          le_d,
  input  logic          ce_s,
  input  logic          ce_d,
  input  logic [AW-1:0] addr_s,
  output logic [AW-1:0] lat_q,
  output logic [AW-1:0] addr_next,
  output logic          start,
  output logic          acc_done
);
  localparam int CW = (ACC_LAT < 1) ? 1 : $clog2(ACC_LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(ACC_LAT);

  logic [CW-1:0] cnt_q;
  logic          ce_fall, le_fall, addr_move;

  always_comb begin
    addr_next = le_s ? lat_q : addr_s;
    ce_fall   = ce_d & ~ce_s;
    le_fall   = le_d & ~le_s;
    addr_move = ~le_s & (addr_s != lat_q);
    start     = ce_fall | le_fall | addr_move;
    acc_done  = (cnt_q == '0) & ~start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      cnt_q <= '0;
    end else begin
      lat_q <= addr_next;
      if (start)
        cnt_q <= LOAD;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/frd_cfg_regs.sv
// Identifier, protection, status, query and burst configuration registers
module frd_cfg_regs
  import flash_rd_pkg::*;
#(
  parameter int           DW         = 32,
  parameter logic [DW-1:0] SIG_WORD   = 32'h5A17_0C3E,
  parameter logic [DW-1:0] PROT_WORD  = 32'h0000_0003,
  parameter logic [DW-1:0] STAT_WORD  = 32'h0000_0080,
  parameter logic [DW-1:0] QUERY_WORD = 32'h0051_5259
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [2:0]    rd_idx,
  output logic [DW-1:0] rd_word,
  output logic          sync_mode
);
  localparam logic [DW-1:0] BCFG_RST = DW'(1);

  logic [DW-1:0] bcfg_q;

  always_ff @(posedge clk) begin
    if (rst)
      bcfg_q <= BCFG_RST;
    else if (cfg_we)
      bcfg_q <= cfg_wdata;
  end

  assign sync_mode = ~bcfg_q[0];

  always_comb begin
    case (rd_idx)
      RIDX_SIG:   rd_word = SIG_WORD;
      RIDX_PROT:  rd_word = PROT_WORD;
      RIDX_STAT:  rd_word = STAT_WORD;
      RIDX_QUERY: rd_word = QUERY_WORD;
      RIDX_BCFG:  rd_word = bcfg_q;
      default:    rd_word = '0;
    endcase
  end
endmodule

// File: rtl/frd_array.sv
// Behavioural word array, one write port and one registered read port
module frd_array #(
  parameter int AAW = 9,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [AAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AAW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_rd_frontend.sv
module flash_rd_frontend
  import flash_rd_pkg::*;
#(
  parameter int            AW         = 10,
  parameter int            DW         = 32,
  parameter int            ACC_LAT    = 3,
  parameter logic [DW-1:0] SIG_WORD   = 32'h5A17_0C3E,
  parameter logic [DW-1:0] PROT_WORD  = 32'h0000_0003,
  parameter logic [DW-1:0] STAT_WORD  = 32'h0000_0080,
  parameter logic [DW-1:0] QUERY_WORD = 32'h0051_5259
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          od_n,
  input  logic          le_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive,
  output logic          rd_valid,
  output logic          rd_sync,
  output logic          sync_mode
);
  localparam int AAW = AW - 1;
  localparam int BW  = AW + DW;

  strobe_t       str_in, str_s, str_d;
  logic [BW-1:0] bus_s;
  logic [AW-1:0] addr_s, lat_q, addr_next;
  logic [DW-1:0] wdata_s, reg_word, arr_word, sel_word;
  logic          start, acc_done, rd_cond, we_rise, cfg_we, arr_we, le_s;

  assign str_in = {ce_n, oe_n, we_n, od_n, le_n};

  frd_sync #(.W(5), .RST_VAL(STROBE_IDLE)) u_str_sync (
    .clk(clk), .rst(rst), .d(str_in), .q(str_s)
  );

  frd_sync #(.W(BW), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst), .d({addr, wdata}), .q(bus_s)
  );

  assign addr_s  = bus_s[BW-1:DW];
  assign wdata_s = bus_s[DW-1:0];
  assign le_s    = str_s.le_n;

  // Previous sampled strobes for edge detection
  always_ff @(posedge clk) begin
    if (rst) str_d <= STROBE_IDLE;
    else     str_d <= str_s;
  end

  frd_addr_latch #(.AW(AW), .ACC_LAT(ACC_LAT)) u_latch (
    .clk(clk), .rst(rst),
    .le_s(str_s.le_n), .le_d(str_d.le_n),
    .ce_s(str_s.ce_n), .ce_d(str_d.ce_n),
    .addr_s(addr_s), .lat_q(lat_q), .addr_next(addr_next),
    .start(start), .acc_done(acc_done)
  );

  // Cycle decode
  always_comb begin
    rd_cond = ~str_s.ce_n & ~str_s.oe_n & str_s.we_n & str_s.od_n;
    we_rise = str_s.we_n & ~str_d.we_n & ~str_s.ce_n;
    cfg_we  = we_rise & addr_s[AW-1] & (addr_s[2:0] == RIDX_BCFG);
    arr_we  = we_rise & ~addr_s[AW-1];
  end

  frd_cfg_regs #(
    .DW(DW), .SIG_WORD(SIG_WORD), .PROT_WORD(PROT_WORD),
    .STAT_WORD(STAT_WORD), .QUERY_WORD(QUERY_WORD)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(wdata_s),
    .rd_idx(lat_q[2:0]), .rd_word(reg_word), .sync_mode(sync_mode)
  );

  frd_array #(.AAW(AAW), .DW(DW)) u_array (
    .clk(clk), .we(arr_we), .waddr(addr_s[AAW-1:0]), .wdata(wdata_s),
    .raddr(lat_q[AAW-1:0]), .rdata(arr_word)
  );

  assign sel_word = lat_q[AW-1] ? reg_word : arr_word;

  // Registered bus outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_drive <= 1'b0;
      rd_valid <= 1'b0;
      rd_sync  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_drive <= rd_cond;
      rd_valid <= rd_cond & acc_done;
      rd_sync  <= rd_cond & sync_mode & ~addr_next[AW-1];
      rd_data  <= (rd_cond & acc_done) ? sel_word : '0;
    end
  end
endmodule

// File: rtl/frd_checker.sv
module frd_checker #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] rd_data,
  input logic          rd_drive,
  input logic          rd_valid,
  input logic          rd_sync,
  input logic          sync_mode,
  input logic          le_s,
  input logic [AW-1:0] lat_q,
  input logic          start,
  input logic          cfg_we
);
  assert_valid_needs_drive_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_drive);

  assert_idle_data_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  assert_start_blocks_valid_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> !rd_valid);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $past(le_s) |-> $stable(lat_q));

  assert_sync_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_mode) |-> $past(cfg_we));

  assert_reg_space_async_R9: assert property (@(posedge clk) disable iff (rst)
    rd_sync |-> !lat_q[AW-1]);

  assert_reset_async_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sync_mode);
endmodule

bind flash_rd_frontend frd_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .rd_drive(rd_drive),
  .rd_valid(rd_valid), .rd_sync(rd_sync), .sync_mode(sync_mode),
  .le_s(le_s), .lat_q(lat_q), .start(start), .cfg_we(cfg_we)
);

// File: tb/flash_rd_frontend_tb.sv
`timescale 1ns/1ps
module flash_rd_frontend_tb;
  localparam int AW  = 10;
  localparam int DW  = 32;
  localparam int LAT = 3;
  localparam logic [31:0] SIGW = 32'h5A17_0C3E;
  localparam logic [31:0] PROW = 32'h0000_0003;
  localparam logic [31:0] STAW = 32'h0000_0080;
  localparam logic [31:0] QRYW = 32'h0051_5259;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, od_n = 1'b1, le_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic rd_drive, rd_valid, rd_sync, sync_mode;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_rd_frontend #(.AW(AW), .DW(DW), .ACC_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .od_n(od_n), .le_n(le_n), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .rd_drive(rd_drive), .rd_valid(rd_valid),
    .rd_sync(rd_sync), .sync_mode(sync_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    bit ce, oe, we, od, le;
    bit [AW-1:0] a;
    bit [DW-1:0] d;
  } snap_t;

  snap_t hist[$];
  bit [DW-1:0] m_mem [int];
  bit [AW-1:0] m_lat;
  int          m_cnt;
  bit [DW-1:0] m_cfg;
  bit          e_drive, e_valid, e_sync, e_mode;
  bit [DW-1:0] e_data;

  function automatic bit [DW-1:0] lookup(input bit [AW-1:0] a);
    if (a[AW-1]) begin
      case (a[2:0])
        3'd0: return SIGW;
        3'd1: return PROW;
        3'd2: return STAW;
        3'd3: return QRYW;
        3'd4: return m_cfg;
        default: return '0;
      endcase
    end
    return m_mem.exists(int'(a[AW-2:0])) ? m_mem[int'(a[AW-2:0])] : '0;
  endfunction

  function automatic snap_t idle_snap();
    snap_t s;
    s.ce = 1; s.oe = 1; s.we = 1; s.od = 1; s.le = 1; s.a = '0; s.d = '0;
    return s;
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) hist.push_back(idle_snap());
    forever begin
      @(posedge clk);
      begin
        snap_t now, S, P;
        bit cond, start, done;
        bit [AW-1:0] anext;
        now.ce = ce_n; now.oe = oe_n; now.we = we_n; now.od = od_n;
        now.le = le_n; now.a = addr; now.d = wdata;
        if (rst) begin
          m_lat = '0; m_cnt = 0; m_cfg = 1;
          e_drive = 0; e_valid = 0; e_sync = 0; e_data = '0; e_mode = 0;
          hist.push_back(idle_snap());
        end else begin
          S = hist[1];  // sampled two edges ago
          P = hist[0];  // three edges ago
          cond  = !S.ce && !S.oe && S.we && S.od;
          start = (P.ce && !S.ce) || (P.le && !S.le) || (!S.le && S.a != m_lat);
          anext = S.le ? m_lat : S.a;
          done  = (m_cnt == 0) && !start;
          e_drive = cond;
          e_valid = cond && done;
          e_data  = e_valid ? lookup(m_lat) : '0;
          e_sync  = cond && e_mode && !anext[AW-1];
          if (S.we && !P.we && !S.ce) begin
            if (S.a[AW-1]) begin
              if (S.a[2:0] == 3'd4) m_cfg = S.d;
            end else m_mem[int'(S.a[AW-2:0])] = S.d;
          end
          m_lat = anext;
          if (start) m_cnt = LAT;
          else if (m_cnt > 0) m_cnt--;
          e_mode = !m_cfg[0];
          hist.push_back(now);
        end
        void'(hist.pop_front());
      end
      #1;
      if (!finished) begin
        chk("R2 rd_drive per-cycle", {31'b0, rd_drive}, {31'b0, e_drive});
        chk("R3 rd_valid per-cycle", {31'b0, rd_valid}, {31'b0, e_valid});
        chk("R3 rd_data per-cycle", rd_data, e_data);
        chk("R9 rd_sync per-cycle", {31'b0, rd_sync}, {31'b0, e_sync});
        chk("R8 sync_mode per-cycle", {31'b0, sync_mode}, {31'b0, e_mode});
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_n = 0; oe_n = 1; we_n = 1; le_n = 0; addr = a; wdata = d;
    cyc(3); we_n = 0;
    cyc(3); we_n = 1;
    cyc(3); ce_n = 1;
    cyc(4);
  endtask

  task automatic read_at(input logic [AW-1:0] a);
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; od_n = 1; le_n = 0; addr = a;
    cyc(10);
  endtask

  function automatic logic [AW-1:0] reg_addr(input int idx);
    return {1'b1, {(AW-4){1'b0}}, 3'(idx)};
  endfunction

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    cyc(4);
    // R1: reset state
    chk("R1 rd_drive in reset", {31'b0, rd_drive}, 32'd0);
    chk("R1 rd_valid in reset", {31'b0, rd_valid}, 32'd0);
    chk("R1 rd_data in reset", rd_data, 32'd0);
    chk("R1 sync_mode in reset", {31'b0, sync_mode}, 32'd0);
    rst = 0;
    cyc(4);
    chk("R1 rd_drive after reset", {31'b0, rd_drive}, 32'd0);

    // R10: array writes
    bus_write(10'd5, 32'hA5A5_0005);
    bus_write(10'd6, 32'h1234_0006);
    bus_write(10'd300, 32'hCAFE_012C);

    // R6 / R10: transparent reads
    read_at(10'd5);
    chk("R6 R10 read word 5", rd_data, 32'hA5A5_0005);
    chk("R2 drive during read", {31'b0, rd_drive}, 32'd1);

    // R4: address change restarts the access
    @(negedge clk); addr = 10'd300;
    cyc(3);
    chk("R4 valid drops after address change", {31'b0, rd_valid}, 32'd0);
    cyc(7);
    chk("R10 read word 300", rd_data, 32'hCAFE_012C);

    // R3: latency edge for a new address
    @(negedge clk); addr = 10'd6;
    cyc(LAT + 3);
    chk("R3 not valid one edge early", {31'b0, rd_valid}, 32'd0);
    cyc(1);
    chk("R3 valid at start plus ACC_LAT+3", {31'b0, rd_valid}, 32'd1);
    chk("R3 data at latency", rd_data, 32'h1234_0006);

    // R5: latch holds while le high
    @(negedge clk); le_n = 1;
    cyc(4);
    @(negedge clk); addr = 10'd5;
    cyc(10);
    chk("R5 latched word kept", rd_data, 32'h1234_0006);
    chk("R5 no restart while latched", {31'b0, rd_valid}, 32'd1);

    // R4: latch strobe falling restarts; transparent again picks new address
    @(negedge clk); le_n = 0;
    cyc(3);
    chk("R4 valid drops on latch strobe fall", {31'b0, rd_valid}, 32'd0);
    cyc(7);
    chk("R6 transparent after fall", rd_data, 32'hA5A5_0005);

    // R4: chip select falling restarts
    @(negedge clk); ce_n = 1;
    cyc(4);
    chk("R2 no drive with chip select high", {31'b0, rd_drive}, 32'd0);
    chk("R3 data zero when not valid", rd_data, 32'd0);
    @(negedge clk); ce_n = 0;
    cyc(3);
    chk("R4 not valid right after chip select fall", {31'b0, rd_valid}, 32'd0);
    cyc(7);
    chk("R4 valid after chip select restart", {31'b0, rd_valid}, 32'd1);

    // R2: output inhibit and read strobe
    @(negedge clk); od_n = 0;
    cyc(4);
    chk("R2 inhibit stops drive", {31'b0, rd_drive}, 32'd0);
    @(negedge clk); od_n = 1; oe_n = 1;
    cyc(4);
    chk("R2 read strobe high stops drive", {31'b0, rd_drive}, 32'd0);
    @(negedge clk); oe_n = 0;
    cyc(4);
    chk("R2 drive back", {31'b0, rd_drive}, 32'd1);

    // R7: register space
    read_at(reg_addr(0)); chk("R7 identifier", rd_data, SIGW);
    read_at(reg_addr(1)); chk("R7 protection", rd_data, PROW);
    read_at(reg_addr(2)); chk("R7 status", rd_data, STAW);
    read_at(reg_addr(3)); chk("R7 query", rd_data, QRYW);
    read_at(reg_addr(4)); chk("R7 R8 burst config reset value", rd_data, 32'd1);
    read_at(reg_addr(6)); chk("R7 unused index reads zero", rd_data, 32'd0);
    @(negedge clk); ce_n = 1; oe_n = 1; cyc(4);

    // R8: enter synchronous mode
    chk("R8 async before config write", {31'b0, sync_mode}, 32'd0);
    bus_write(reg_addr(2), 32'h0);
    chk("R8 write to other register ignored", {31'b0, sync_mode}, 32'd0);
    bus_write(reg_addr(4), 32'h0000_0010);
    chk("R8 sync after bit0 cleared", {31'b0, sync_mode}, 32'd1);

    // R9: array reads synchronous, register reads asynchronous
    read_at(10'd5);
    chk("R9 array read is sync", {31'b0, rd_sync}, 32'd1);
    chk("R10 array data in sync mode", rd_data, 32'hA5A5_0005);
    read_at(reg_addr(2));
    chk("R9 status read forced async", {31'b0, rd_sync}, 32'd0);
    read_at(reg_addr(4));
    chk("R9 config read forced async", {31'b0, rd_sync}, 32'd0);
    chk("R8 config readback", rd_data, 32'h0000_0010);
    @(negedge clk); ce_n = 1; oe_n = 1; cyc(4);

    bus_write(reg_addr(4), 32'h0000_0001);
    chk("R8 bit0 set returns async", {31'b0, sync_mode}, 32'd0);
    bus_write(reg_addr(4), 32'h0000_0000);
    chk("R8 sync again", {31'b0, sync_mode}, 32'd1);

    // R11: reset returns to async
    @(negedge clk); rst = 1;
    cyc(3);
    @(negedge clk); rst = 0;
    cyc(3);
    chk("R11 async after reset", {31'b0, sync_mode}, 32'd0);
    read_at(reg_addr(4));
    chk("R11 config back to reset value", rd_data, 32'd1);
    read_at(10'd6);
    chk("R11 array read async after reset", {31'b0, rd_sync}, 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule